// File: doc/BRIEF.md
# Half-Bridge Cross-Conduction Interlock

This clocked controller sits between a motor-control processor and two gate drivers. One gate driver serves an internal high-side switch and the other an external low-side transistor. The controller takes a high-side command, a low-side command, an enable and a mode select, and from them produces one registered gate-on request per switch. Enable low puts the block to sleep. When enable rises, both commands are ignored for a programmable number of clock cycles so that the bootstrap capacitor can charge.

The mode select chooses between two modes. With the select low, the two requests follow their commands independently. With the select high, the two switches form a half-bridge. In that mode the high-side command always wins, and the low side is released only after a status input reports that the high-side gate has discharged. A typical use is PWM on the high-side command while the low-side command and the mode select stay high. The low side then carries the freewheeling current whenever the high side is off.

All level inputs pass through two-flop synchronizers. After reset, the synchronizers hold command low, enable low, discharge status low and mode select high. The block therefore starts in the safe interlocked state. A separate fault supervisor drives two force-off inputs, and these take priority over the computed requests.

Top module: `hb_interlock`

## Requirements
- R1: With enable low, both requests are 0 on the third rising edge after enable falls and stay 0 whatever the commands are.
- R2: After enable rises, both requests stay 0 for BLANK_CYC+2 rising edges. On the next edge they take their commanded values.
- R3: With the mode select at 0, each request follows its own command, and both requests may be 1 at the same time. The discharge status has no effect in this mode.
- R4: With the mode select at 1, the two requests are never 1 together. If both commands are 1, the high-side request is 1 and the low-side request is 0.
- R5: With the mode select at 1, the low-side request becomes 1 only when the synchronized discharge status is 1.
- R6: While reset is active, both requests are 0.
- R7: A force-off input clears its request on the next rising edge. A high side that is forced off releases the low side in mode 1 only once the discharge status is 1.
- R8: With the mode select at 1 and the low side on, a rising high-side command clears the low-side request three edges after the command changes. The high-side request becomes 1 one edge later.
- R9: Once active, a command change reaches its request on the third rising edge after the change: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low puts the block to sleep |
| cfg_i | input | 1 | Mode select: 1 = interlocked half-bridge, 0 = independent |
| hs_cmd_i | input | 1 | High-side command |
| ls_cmd_i | input | 1 | Low-side command |
| hs_gate_low_i | input | 1 | Status from the gate driver: high-side gate below threshold |
| hs_off_i | input | 1 | Force-off for the high side from the fault supervisor (synchronous) |
| ls_off_i | input | 1 | Force-off for the low side from the fault supervisor (synchronous) |
| hs_req_o | output | 1 | High-side gate-on request |
| ls_req_o | output | 1 | Low-side gate-on request |

## Verification
The bench builds the block with BLANK_CYC set to 8 instead of a value near the default of 2000. With that setting, the exact edge at which the blanking window ends can be checked directly, and the block can be put to sleep and woken again within a few dozen cycles. The bench keeps the two-stage synchronizer at its fixed depth. This lets it check, edge by edge, the three-edge command latency and the one-cycle gap that the interlock inserts when the high side takes over from the low side.

// File: rtl/hb_interlock.sv
module hb_interlock #(
  parameter int BLANK_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic cfg_i,
  input  logic hs_cmd_i,
  input  logic ls_cmd_i,
  input  logic hs_gate_low_i,
  input  logic hs_off_i,
  input  logic ls_off_i,
  output logic hs_req_o,
  output logic ls_req_o
);

  localparam int CW = (BLANK_CYC > 0) ? $clog2(BLANK_CYC + 1) : 1;
  localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYC);

  logic [1:0] en_ff, cfg_ff, hs_ff, ls_ff, dis_ff;
  logic [CW-1:0] blank_cnt;
  logic hs_q, ls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ff  <= 2'b00;
      cfg_ff <= 2'b11;
      hs_ff  <= 2'b00;
      ls_ff  <= 2'b00;
      dis_ff <= 2'b00;
    end else begin
      en_ff  <= {en_ff[0],  en_i};
      cfg_ff <= {cfg_ff[0], cfg_i};
      hs_ff  <= {hs_ff[0],  hs_cmd_i};
      ls_ff  <= {ls_ff[0],  ls_cmd_i};
      dis_ff <= {dis_ff[0], hs_gate_low_i};
    end
  end

  wire en_s  = en_ff[1];
  wire cfg_s = cfg_ff[1];
  wire hs_s  = hs_ff[1];
  wire ls_s  = ls_ff[1];
  wire dis_s = dis_ff[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               blank_cnt <= BLANK_LD;
    else if (!en_s)           blank_cnt <= BLANK_LD;
    else if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
  end

  wire live = en_s && (blank_cnt == '0);

  wire hs_nxt = live && hs_s && !hs_off_i && !(cfg_s && ls_q);
  wire ls_nxt = live && ls_s && !ls_off_i &&
                (!cfg_s || (!hs_s && !hs_q && dis_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_nxt;
      ls_q <= ls_nxt;
    end
  end

  assign hs_req_o = hs_q;
  assign ls_req_o = ls_q;

  AST_SLEEP_OFF:   assert property (@(posedge clk) disable iff (!rst_n) !en_s |=> (!hs_req_o && !ls_req_o)); // R1
  AST_BLANK_OFF:   assert property (@(posedge clk) disable iff (!rst_n) (en_s && blank_cnt != '0) |=> (!hs_req_o && !ls_req_o)); // R2
  AST_INDEP_HS:    assert property (@(posedge clk) disable iff (!rst_n) (live && !cfg_s && hs_s && !hs_off_i) |=> hs_req_o); // R3
  AST_NO_OVERLAP:  assert property (@(posedge clk) disable iff (!rst_n) cfg_s |=> !(hs_req_o && ls_req_o)); // R4
  AST_LS_WAIT_DIS: assert property (@(posedge clk) disable iff (!rst_n) (cfg_s && !dis_s) |=> !ls_req_o); // R5
  AST_HS_KILL:     assert property (@(posedge clk) disable iff (!rst_n) hs_off_i |=> !hs_req_o); // R7
  AST_LS_KILL:     assert property (@(posedge clk) disable iff (!rst_n) ls_off_i |=> !ls_req_o); // R7
  AST_HS_GAP:      assert property (@(posedge clk) disable iff (!rst_n) (cfg_s && ls_req_o) |=> !hs_req_o); // R8

endmodule

// File: tb/hb_interlock_tb_top.sv
module hb_interlock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cfg = 1'b1, hs = 1'b0, ls = 1'b0, dis = 1'b0, hs_off = 1'b0, ls_off = 1'b0;
  logic hs_req, ls_req;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct { logic hs; logic ls; string tag; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_interlock #(.BLANK_CYC(BLANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .cfg_i(cfg),
    .hs_cmd_i(hs), .ls_cmd_i(ls), .hs_gate_low_i(dis),
    .hs_off_i(hs_off), .ls_off_i(ls_off),
    .hs_req_o(hs_req), .ls_req_o(ls_req)
  );

  initial begin : monitor
    forever begin
      wait (sb_q.size() != 0);
      #1;
      while (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (hs_req !== e.hs || ls_req !== e.ls) begin
          errors++;
          $display("FAIL %s: hs/ls actual=%b%b expected=%b%b", e.tag, hs_req, ls_req, e.hs, e.ls);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic h, input logic l, input string tag);
    exp_t e;
    e.hs = h; e.ls = l; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin : driver
    step(3);
    expect_out(0, 0, "R6 in reset");
    step(1);
    rst_n = 1'b1;
    cfg = 1'b0;
    step(4);
    expect_out(0, 0, "R6 after reset");
    // R2 blanking, independent mode
    en = 1'b1; hs = 1'b1;
    step(BLANK + 2); expect_out(0, 0, "R2 still blanked");
    step(1);         expect_out(1, 0, "R2 window over");
    // R3 independent, both on, discharge status ignored
    ls = 1'b1;
    step(4); expect_out(1, 1, "R3 both on");
    hs = 1'b0;
    step(4); expect_out(0, 1, "R3 ls alone");
    ls = 1'b0;
    step(4); expect_out(0, 0, "R3 both off");
    // R9 latency
    hs = 1'b1;
    step(2); expect_out(0, 0, "R9 two edges");
    step(1); expect_out(1, 0, "R9 third edge");
    // R4 interlock priority
    cfg = 1'b1; ls = 1'b1;
    step(5); expect_out(1, 0, "R4 hs priority");
    // R5 wait for discharge status
    hs = 1'b0;
    step(6); expect_out(0, 0, "R5 no discharge yet");
    dis = 1'b1;
    step(2); expect_out(0, 0, "R5 status in sync");
    step(1); expect_out(0, 1, "R5 ls released");
    // R8 high side takes over
    hs = 1'b1; dis = 1'b0;
    step(3); expect_out(0, 0, "R8 ls dropped, gap");
    step(1); expect_out(1, 0, "R8 hs on");
    // R7 force-off
    hs_off = 1'b1; hs = 1'b0;
    step(1); expect_out(0, 0, "R7 hs forced off");
    step(5); expect_out(0, 0, "R7 ls held, not discharged");
    dis = 1'b1;
    step(3); expect_out(0, 1, "R7 ls after discharge");
    ls_off = 1'b1;
    step(1); expect_out(0, 0, "R7 ls forced off");
    ls_off = 1'b0; hs_off = 1'b0;
    step(1); expect_out(0, 1, "R7 ls restored");
    // R1 sleep
    en = 1'b0;
    step(3); expect_out(0, 0, "R1 asleep");
    hs = 1'b1; dis = 1'b0;
    step(6); expect_out(0, 0, "R1 commands ignored");
    // wake in interlocked mode with both commands high
    en = 1'b1;
    step(BLANK + 2); expect_out(0, 0, "R2 second wake blanked");
    step(1);         expect_out(1, 0, "R4 hs wins after wake");
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule